// File: doc/BRIEF.md
# Test-and-Set-Bits Sequencer

This block carries out one read-modify-write instruction for an accumulator CPU whose accumulator can be 8 or 16 bits wide. The instruction ORs the accumulator into a memory operand and records in the zero flag whether the accumulator and the original operand share any set bit. The block drives a byte-wide synchronous bus itself and keeps the cycle count of the real instruction. The cycle count depends on the addressing form, on the accumulator width and on the alignment of the direct page register.

The surrounding core raises `start` for one cycle, in the cycle in which the opcode byte is fetched. In that cycle it also presents the program counter, the accumulator, the width mode, the direct page register and the data bank register. The sequencer captures these values, fetches the opcode and the operand bytes, reads the target, spends one internal cycle, and writes the merged value back. `done` marks the last write. `zFlag` carries the zero flag. The block modifies no other flag.

Top module: `tsbSequencer`

## Requirements
- R1: Opcode 0x0C selects the absolute form. The operand is a 16-bit address fetched low byte first from pc+1 and pc+2. The effective address is {data bank, high byte, low byte}. With an 8-bit accumulator the instruction takes 6 cycles, counting the `start` cycle as cycle 1 and the `done` cycle as the last.
- R2: Opcode 0x04 selects the direct page form. It has one offset byte at pc+1. The effective address is {0x00, direct page + offset}, where the sum wraps at 16 bits. With an 8-bit accumulator and a direct page low byte of zero, the instruction takes 5 cycles.
- R3: When `accWide`=1, each form takes 2 more cycles and the operand is 16 bits wide. The high byte lies at effective address + 1. In the absolute form that address carries into the bank. In the direct page form it wraps inside bank 0.
- R4: In the direct page form, one internal cycle is inserted after the offset fetch whenever the direct page low byte is nonzero.
- R5: Every written byte equals the memory byte read at that address ORed with the matching accumulator byte. With `accWide`=0, the accumulator high byte has no effect and the byte at effective address + 1 is neither read nor written.
- R6: `zFlag` is 1 when the AND of the accumulator and the original operand is zero over the active width, and 0 otherwise. It is valid in the `done` cycle and holds its value until the next instruction's internal cycle. Reset clears it to 0.
- R7: The bus sequence is fixed: the opcode and operand fetches, the read of the low byte, the read of the high byte (16-bit only), one cycle with no access, then the write of the high byte (16-bit only) and finally the write of the low byte. No cycle has more than one access.
- R8: `done` is high for exactly one cycle, the cycle of the final low-byte write.
- R9: Any other opcode ends the instruction after the fetch cycle, with no further access and no `done`.
- R10: In the `start` cycle the block reads the opcode at `pcIn`. `busy` is high from the cycle after `start` through the `done` cycle. After reset, `busRd`, `busWr`, `done` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opcode fetch strobe. Begins one instruction while idle |
| pcIn | input | 24 | Bank and program counter of the opcode byte |
| accIn | input | 16 | Accumulator value |
| accWide | input | 1 | 1 selects a 16-bit accumulator, 0 selects 8 bits |
| dpIn | input | 16 | Direct page register |
| dbIn | input | 8 | Data bank register |
| busAddr | output | 24 | Bus address |
| busRd | output | 1 | Read strobe. Data is sampled at the closing edge |
| busWr | output | 1 | Write strobe |
| busWdata | output | 8 | Write data |
| busRdata | input | 8 | Read data |
| zFlag | output | 1 | Zero flag |
| done | output | 1 | One-cycle pulse on the final write |
| busy | output | 1 | Instruction in progress after the fetch cycle |

## Verification
Every cycle, the embedded assertions check four things: bus exclusivity, that writes start only after the internal cycle, that the high-byte write comes before the low-byte write, and that `done` is a single pulse. They also check that written bytes cover the accumulator bits, that direct page accesses stay in bank 0, that the zero flag moves only at the internal cycle, and that an unknown opcode stops at once. Some properties need the whole instruction and a memory that answers reads, so only the bench scenarios can show them. These are the total cycle count for each combination of width, form and direct page alignment, the exact addresses reached at bank and page edges, the merged memory contents and the zero flag value.

// File: rtl/tsbPkg.sv
package tsbPkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int BANK_W = 8;
  localparam int ADDR_W = WORD_W + BANK_W;

  localparam logic [BYTE_W-1:0] OP_ABSOLUTE = 8'h0C;
  localparam logic [BYTE_W-1:0] OP_DIRECT   = 8'h04;

  typedef enum logic [2:0] {
    A_PC0, A_PC1, A_PC2, A_EA0, A_EA1
  } addrSel_e;

  typedef enum logic [3:0] {
    S_IDLE, S_OPLO, S_OPHI, S_DPX, S_RDLO, S_RDHI, S_INTL, S_WRHI, S_WRLO
  } state_e;

  typedef struct packed {
    logic     capture;
    logic     takeLo;
    logic     takeHi;
    logic     memLo;
    logic     memHi;
    logic     setZ;
    logic     rd;
    logic     wr;
    addrSel_e aSel;
  } ctrl_t;

  typedef struct packed {
    logic absMode;
    logic wide;
    logic dpOff;
  } status_t;

  function automatic logic opKnown(input logic [BYTE_W-1:0] op);
    return (op == OP_ABSOLUTE) || (op == OP_DIRECT);
  endfunction
endpackage

// File: rtl/tsbCtrl.sv
module tsbCtrl
  import tsbPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [BYTE_W-1:0] busRdata,
  input  status_t           st,
  output ctrl_t             ctl,
  output logic              done,
  output logic              busy
);
  state_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    ctl = '0;
    nxt = state;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.capture = 1'b1;
        ctl.rd      = 1'b1;
        ctl.aSel    = A_PC0;
        if (opKnown(busRdata)) nxt = S_OPLO;
      end
      S_OPLO: begin
        ctl.rd     = 1'b1;
        ctl.aSel   = A_PC1;
        ctl.takeLo = 1'b1;
        if (st.absMode)    nxt = S_OPHI;
        else if (st.dpOff) nxt = S_DPX;
        else               nxt = S_RDLO;
      end
      S_OPHI: begin
        ctl.rd     = 1'b1;
        ctl.aSel   = A_PC2;
        ctl.takeHi = 1'b1;
        nxt        = S_RDLO;
      end
      S_DPX: nxt = S_RDLO;
      S_RDLO: begin
        ctl.rd    = 1'b1;
        ctl.aSel  = A_EA0;
        ctl.memLo = 1'b1;
        nxt       = st.wide ? S_RDHI : S_INTL;
      end
      S_RDHI: begin
        ctl.rd    = 1'b1;
        ctl.aSel  = A_EA1;
        ctl.memHi = 1'b1;
        nxt       = S_INTL;
      end
      S_INTL: begin
        ctl.setZ = 1'b1;
        nxt      = st.wide ? S_WRHI : S_WRLO;
      end
      S_WRHI: begin
        ctl.wr   = 1'b1;
        ctl.aSel = A_EA1;
        nxt      = S_WRLO;
      end
      S_WRLO: begin
        ctl.wr   = 1'b1;
        ctl.aSel = A_EA0;
        nxt      = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign done = (state == S_WRLO);
  assign busy = (state != S_IDLE);

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.rd && ctl.wr)); // R7
  AST_HIGH_BEFORE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    state == S_WRHI |=> (state == S_WRLO) && done); // R7
  AST_WRITE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wr && !$past(ctl.wr) |-> $past(state) == S_INTL); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_UNKNOWN_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) && start && !opKnown(busRdata) |=> !busy); // R9
endmodule

// File: rtl/tsbDatapath.sv
module tsbDatapath
  import tsbPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [WORD_W-1:0] accIn,
  input  logic              accWide,
  input  logic [WORD_W-1:0] dpIn,
  input  logic [BANK_W-1:0] dbIn,
  input  logic [BYTE_W-1:0] busRdata,
  output status_t           st,
  output logic [ADDR_W-1:0] busAddr,
  output logic [BYTE_W-1:0] busWdata,
  output logic              zFlag
);
  logic [ADDR_W-1:0] pcQ;
  logic [WORD_W-1:0] accQ, dpQ, offQ, memQ;
  logic [BANK_W-1:0] dbQ;
  logic              wideQ, absQ, zQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ <= '0; accQ <= '0; dpQ <= '0; dbQ <= '0;
      wideQ <= 1'b0; absQ <= 1'b0;
    end else if (ctl.capture) begin
      pcQ   <= pcIn;
      accQ  <= accIn;
      dpQ   <= dpIn;
      dbQ   <= dbIn;
      wideQ <= accWide;
      absQ  <= (busRdata == OP_ABSOLUTE);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offQ <= '0;
      memQ <= '0;
    end else begin
      if (ctl.takeLo) offQ[BYTE_W-1:0]      <= busRdata;
      if (ctl.takeHi) offQ[WORD_W-1:BYTE_W] <= busRdata;
      if (ctl.capture) offQ[WORD_W-1:BYTE_W] <= '0;
      if (ctl.memLo)  memQ[BYTE_W-1:0]      <= busRdata;
      if (ctl.memHi)  memQ[WORD_W-1:BYTE_W] <= busRdata;
      if (ctl.capture) memQ <= '0;
    end
  end

  logic loHit, hiHit;
  assign loHit = |(accQ[BYTE_W-1:0] & memQ[BYTE_W-1:0]);
  assign hiHit = |(accQ[WORD_W-1:BYTE_W] & memQ[WORD_W-1:BYTE_W]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         zQ <= 1'b0;
    else if (ctl.setZ) zQ <= !(loHit || (wideQ && hiHit));
  end
  assign zFlag = zQ;

  logic [WORD_W-1:0] dpSum;
  logic [ADDR_W-1:0] ea0, ea1, pc1, pc2;
  assign dpSum = dpQ + {{(WORD_W-BYTE_W){1'b0}}, offQ[BYTE_W-1:0]};
  assign ea0   = absQ ? {dbQ, offQ} : {{BANK_W{1'b0}}, dpSum};
  assign ea1   = absQ ? ea0 + ADDR_W'(1) : {{BANK_W{1'b0}}, dpSum + WORD_W'(1)};
  assign pc1   = {pcQ[ADDR_W-1:WORD_W], pcQ[WORD_W-1:0] + WORD_W'(1)};
  assign pc2   = {pcQ[ADDR_W-1:WORD_W], pcQ[WORD_W-1:0] + WORD_W'(2)};

  always_comb begin
    unique case (ctl.aSel)
      A_PC0:   busAddr = pcIn;
      A_PC1:   busAddr = pc1;
      A_PC2:   busAddr = pc2;
      A_EA0:   busAddr = ea0;
      A_EA1:   busAddr = ea1;
      default: busAddr = pcIn;
    endcase
  end

  assign busWdata = (ctl.aSel == A_EA1)
                  ? (memQ[WORD_W-1:BYTE_W] | accQ[WORD_W-1:BYTE_W])
                  : (memQ[BYTE_W-1:0] | accQ[BYTE_W-1:0]);

  assign st.absMode = absQ;
  assign st.wide    = wideQ;
  assign st.dpOff   = |dpQ[BYTE_W-1:0];

  AST_WRITE_COVERS_ACC: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wr && ctl.aSel == A_EA0 |->
      (busWdata & accQ[BYTE_W-1:0]) == accQ[BYTE_W-1:0]); // R5
  AST_DP_IN_BANK0: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rd || ctl.wr) && !absQ && (ctl.aSel == A_EA0 || ctl.aSel == A_EA1)
      |-> busAddr[ADDR_W-1:WORD_W] == '0); // R2
  AST_Z_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.setZ |=> $stable(zFlag)); // R6
endmodule

// File: rtl/tsbSequencer.sv
module tsbSequencer
  import tsbPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [23:0] pcIn,
  input  logic [15:0] accIn,
  input  logic        accWide,
  input  logic [15:0] dpIn,
  input  logic [7:0]  dbIn,
  output logic [23:0] busAddr,
  output logic        busRd,
  output logic        busWr,
  output logic [7:0]  busWdata,
  input  logic [7:0]  busRdata,
  output logic        zFlag,
  output logic        done,
  output logic        busy
);
  ctrl_t   ctl;
  status_t st;

  tsbCtrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .busRdata(busRdata),
    .st(st), .ctl(ctl), .done(done), .busy(busy)
  );

  tsbDatapath uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pcIn(pcIn), .accIn(accIn),
    .accWide(accWide), .dpIn(dpIn), .dbIn(dbIn), .busRdata(busRdata),
    .st(st), .busAddr(busAddr), .busWdata(busWdata), .zFlag(zFlag)
  );

  assign busRd = ctl.rd;
  assign busWr = ctl.wr;
endmodule

// File: tb/tb_tsbSequencer.sv
module tb_tsbSequencer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [23:0] pcIn = '0;
  logic [15:0] accIn = '0;
  logic        accWide = 1'b0;
  logic [15:0] dpIn = '0;
  logic [7:0]  dbIn = '0;
  logic [23:0] busAddr;
  logic        busRd, busWr, zFlag, done, busy;
  logic [7:0]  busWdata, busRdata;

  always #10 clk = ~clk;

  tsbSequencer dut (
    .clk(clk), .rstN(rstN), .start(start), .pcIn(pcIn), .accIn(accIn),
    .accWide(accWide), .dpIn(dpIn), .dbIn(dbIn), .busAddr(busAddr),
    .busRd(busRd), .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata),
    .zFlag(zFlag), .done(done), .busy(busy)
  );

  // byte memory model, aliased on the low 10 address bits
  logic [7:0] mem [1024];
  assign busRdata = mem[busAddr[9:0]];
  always @(posedge clk) if (busWr) mem[busAddr[9:0]] <= busWdata;

  int checks = 0;
  int fails  = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct {
    int          cycles;
    int          reads;
    int          writes;
    logic        z;
    logic [23:0] firstWa;
    logic [23:0] lastWa;
    logic [7:0]  lastWd;
  } exp_t;

  exp_t expQ[$];
  logic doneSeen = 1'b0;

  // monitor: counts the bus activity of each instruction, compares at done
  int cyc = 0, rdN = 0, wrN = 0;
  logic [23:0] firstWa = '0;
  always @(negedge clk) begin
    if (start || busy) begin
      cyc++;
      if (busRd) rdN++;
      if (busWr) begin
        if (wrN == 0) firstWa = busAddr;
        wrN++;
      end
      if (done) begin
        exp_t e;
        if (expQ.size() == 0) begin
          check("R8 unexpected done", 32'd1, 32'd0);
        end else begin
          e = expQ.pop_front();
          check("R1/R2/R3/R4 cycle count", cyc, e.cycles);
          check("R7 read count", rdN, e.reads);
          check("R7 write count", wrN, e.writes);
          check("R7 first write address", firstWa, e.firstWa);
          check("R8 done on low write address", busAddr, e.lastWa);
          check("R5 low write data", busWdata, e.lastWd);
          check("R6 zero flag at done", zFlag, e.z);
        end
        doneSeen = 1'b1;
      end
    end else begin
      cyc = 0; rdN = 0; wrN = 0;
    end
  end

  task automatic clearMem();
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
  endtask

  task automatic runOp(input logic [7:0] op, input logic [23:0] pc, input logic [15:0] acc,
                       input logic wide, input logic [15:0] dp, input logic [7:0] db,
                       input logic [15:0] operand, input logic [15:0] memVal);
    logic        isAbs = (op == 8'h0C);
    logic [15:0] dpSum;
    logic [23:0] ea, ea1;
    logic [15:0] accEff, res;
    exp_t        e;
    dpSum = dp + {8'h00, operand[7:0]};
    ea    = isAbs ? {db, operand} : {8'h00, dpSum};
    ea1   = isAbs ? ea + 24'd1 : {8'h00, dpSum + 16'd1};
    accEff = wide ? acc : {8'h00, acc[7:0]};
    res    = wide ? (memVal | accEff) : {memVal[15:8], memVal[7:0] | accEff[7:0]};
    clearMem();
    mem[pc[9:0]] = op;
    mem[{pc[23:16], pc[15:0] + 16'd1} & 24'h3FF] = operand[7:0];
    if (isAbs) mem[{pc[23:16], pc[15:0] + 16'd2} & 24'h3FF] = operand[15:8];
    mem[ea[9:0]]  = memVal[7:0];
    mem[ea1[9:0]] = memVal[15:8];
    e.cycles  = (isAbs ? 6 : 5) + (wide ? 2 : 0) + ((!isAbs && dp[7:0] != 8'h00) ? 1 : 0);
    e.reads   = 1 + (isAbs ? 2 : 1) + (wide ? 2 : 1);
    e.writes  = wide ? 2 : 1;
    e.z       = ((accEff & memVal & (wide ? 16'hFFFF : 16'h00FF)) == 16'h0000);
    e.firstWa = wide ? ea1 : ea;
    e.lastWa  = ea;
    e.lastWd  = res[7:0];
    expQ.push_back(e);
    doneSeen = 1'b0;
    @(posedge clk); #1;
    start = 1'b1; pcIn = pc; accIn = acc; accWide = wide; dpIn = dp; dbIn = db;
    @(posedge clk); #1;
    start = 1'b0;
    while (!doneSeen) @(negedge clk);
    @(posedge clk); #1;
    check("R5 final low byte", mem[ea[9:0]], res[7:0]);
    check(wide ? "R3 final high byte" : "R5 byte above untouched", mem[ea1[9:0]], res[15:8]);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    clearMem();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R10 reset busRd", busRd, 1'b0);
    check("R10 reset busWr", busWr, 1'b0);
    check("R10 reset done", done, 1'b0);
    check("R10 reset busy", busy, 1'b0);
    check("R6 reset zFlag", zFlag, 1'b0);

    // R1 absolute, 8-bit: no common bits, then common bits
    runOp(8'h0C, 24'h010040, 16'h000F, 1'b0, 16'h0000, 8'h05, 16'h1200, 16'h5AF0);
    runOp(8'h0C, 24'h010040, 16'h0081, 1'b0, 16'h0000, 8'h05, 16'h1300, 16'h0001);
    // R3 absolute, 16-bit, normal and bank carry on the high byte
    runOp(8'h0C, 24'h020080, 16'h1234, 1'b1, 16'h0000, 8'h07, 16'h3456, 16'h4321);
    runOp(8'h0C, 24'h020080, 16'h00FF, 1'b1, 16'h0000, 8'h12, 16'hFFFF, 16'hFF00);
    // R2 direct page aligned, upper accumulator byte ignored (R5)
    runOp(8'h04, 24'h000100, 16'hAA55, 1'b0, 16'h0200, 8'h33, 16'h0010, 16'h33AA);
    // R4 direct page misaligned
    runOp(8'h04, 24'h000100, 16'h0003, 1'b0, 16'h0201, 8'h33, 16'h0010, 16'h0002);
    // R3 direct page 16-bit aligned
    runOp(8'h04, 24'h000140, 16'hF00F, 1'b1, 16'h0300, 8'h44, 16'h0020, 16'h0FF0);
    // R3/R4 direct page 16-bit misaligned with wrap to 0x0000 in bank 0
    runOp(8'h04, 24'h000100, 16'h8001, 1'b1, 16'hFFF5, 8'h55, 16'h000A, 16'h8000);
    repeat (5) @(negedge clk);
    check("R6 zFlag holds after done", zFlag, 1'b0);
    // R5 zero accumulator leaves memory unchanged
    runOp(8'h0C, 24'h010040, 16'h0000, 1'b0, 16'h0000, 8'h03, 16'h0050, 16'h003C);

    // R9 unknown opcode
    clearMem();
    mem[10'h060] = 8'hEA;
    mem[10'h061] = 8'h77;
    @(posedge clk); #1;
    start = 1'b1; pcIn = 24'h000060; accIn = 16'hFFFF; accWide = 1'b1;
    @(negedge clk);
    check("R10 opcode read at pcIn", {busRd, busAddr}, {1'b1, 24'h000060});
    @(posedge clk); #1;
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9 no activity after unknown opcode", {busy, busRd, busWr, done}, 4'b0000);
    end
    check("R9 memory untouched", mem[10'h061], 8'h77);
    check("R6 zFlag held across unknown opcode", zFlag, 1'b1);
    check("R8 no pending expectation", expQ.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule